// File: doc/BRIEF.md
# Pin Bank Controller with Edge Interrupts

This block manages thirty-two general-purpose pins through a small register bus. For each pin it holds a direction bit, an output latch and a synchronized copy of the pin level. Software changes output bits and trigger enables through separate write-one set and clear addresses, so it never needs a read-modify-write sequence. The pin level is visible to software in every direction setting, so software can also read back the level of a pin it is driving.

Each pin can be armed to detect a rising edge, a falling edge, both or neither. A detected edge latches a bit in an interrupt status register, and software clears that bit by writing one to it. The pins form two sixteen-pin halves. Each half has its own interrupt line, and a per-half enable bit gates that line.

The block is built from four parts: a two-flop input synchronizer with an edge detector, a configuration register file, an interrupt status unit and a combinational read multiplexer. It has no sequencing state of its own, so no state machine is needed. Register reads complete in the same cycle and writes take effect at the next clock edge.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset the direction register (0x10) reads 0xFFFFFFFF (all inputs) and `pin_oe` is 0. The output latch (0x14), both trigger enables (0x24, 0x2C), the status register (0x34) and the half enable register (0x08) read 0, and both `irq_o` lines are low.
- R2: Direction bit i set to 1 makes pin i an input and set to 0 makes it an output, so `pin_oe` is the bitwise inverse of the register at 0x10.
- R3: Writing a mask to 0x18 drives the masked bits of `pin_out` high and leaves the other bits unchanged. Writing to 0x14 loads the whole latch. Reads of 0x14, 0x18 and 0x1C return the latch.
- R4: Writing a mask to 0x1C drives the masked bits of `pin_out` low and leaves the other bits unchanged.
- R5: A read of 0x20 returns the pin level two clock edges after it was applied, whatever the direction setting. A read one edge after a change still shows the old level.
- R6: Writing a mask to 0x24 or 0x28 sets or clears the rising-edge enables, and writing to 0x2C or 0x30 does the same for the falling-edge enables. Zero bits in the mask leave their enables unchanged. The rising enables read back at 0x24 and 0x28, and the falling enables at 0x2C and 0x30.
- R7: A rising edge on a pin whose rising enable is set sets its status bit three clock edges after the pin change. A rising edge on a pin without that enable sets nothing.
- R8: A falling edge on a pin whose falling enable is set sets its status bit in the same way. A pin with both enables set reports both edges.
- R9: Writing 1 to a status bit at 0x34 clears it. Writing 0 leaves it unchanged, and no other write clears it.
- R10: When an edge event and a write-one clear hit the same status bit in the same cycle, the bit stays set.
- R11: `irq_o[0]` is high exactly when bit 0 of 0x08 is set and any of status bits 15:0 is set. `irq_o[1]` is high exactly when bit 1 is set and any of status bits 31:16 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| pin_in | input | 32 | Pin levels, asynchronous to `clk` |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Per-pin output enable, 1 means driving |
| irq_o | output | 2 | Interrupt line per sixteen-pin half |

## Verification
The properties assume that `pin_in` is already free of metastability when it is sampled, so that the synchronizer behaves as a plain delay line. They also assume that every write strobe lasts exactly one cycle. The bench honours both assumptions: it changes pins and bus signals only on the falling clock edge, holds each access for one cycle and returns `bus_sel` to 0 afterwards. Before each pin is swept, the bench clears the enables and status left by the previous case, so that every edge it expects comes from a known earlier level.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_BANK_EN  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_DIR      = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_OUT      = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_OUT_SET  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_OUT_CLR  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_IN       = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_STAT     = 8'h34;

    // One-hot write strobes for the configuration registers
    typedef struct packed {
        logic bank_en;
        logic dir;
        logic out_wr;
        logic out_set;
        logic out_clr;
        logic rise_set;
        logic rise_clr;
        logic fall_set;
        logic fall_clr;
    } cfg_wr_t;

    function automatic cfg_wr_t decode_cfg_write(input logic we, input logic [ADDR_W-1:0] a);
        cfg_wr_t s;
        s.bank_en  = we && (a == OFS_BANK_EN);
        s.dir      = we && (a == OFS_DIR);
        s.out_wr   = we && (a == OFS_OUT);
        s.out_set  = we && (a == OFS_OUT_SET);
        s.out_clr  = we && (a == OFS_OUT_CLR);
        s.rise_set = we && (a == OFS_RISE_SET);
        s.rise_clr = we && (a == OFS_RISE_CLR);
        s.fall_set = we && (a == OFS_FALL_SET);
        s.fall_clr = we && (a == OFS_FALL_CLR);
        return s;
    endfunction

    // Write-one set / write-one clear update of a bit vector
    function automatic logic [31:0] w1_update(input logic [31:0] cur, input logic [31:0] mask,
                                              input logic do_set, input logic do_clr);
        logic [31:0] r;
        r = cur;
        if (do_set) begin
            r = r | mask;
        end else if (do_clr) begin
            r = r & ~mask;
        end
        return r;
    endfunction

endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] rise,
    output logic [NPINS-1:0] fall
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [CHAIN_W-1:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[CHAIN_W-2:0], pin_in[i]};
            end
        end

        // chain_q[SYNC_STAGES-1] is the synchronized level,
        // chain_q[SYNC_STAGES] is that level one cycle earlier
        assign level[i] = chain_q[SYNC_STAGES-1];
        assign rise[i]  =  chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
        assign fall[i]  = ~chain_q[SYNC_STAGES-1] &  chain_q[SYNC_STAGES];
    end

endmodule

// File: rtl/pin_cfg_regs.sv
module pin_cfg_regs
    import pin_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int NBANKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_wr_t           stb,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  rise_en_q,
    output logic [NPINS-1:0]  fall_en_q,
    output logic [NBANKS-1:0] bank_en_q
);

    logic [31:0] wide_w;
    logic [31:0] out_nx, rise_nx, fall_nx;

    always_comb begin
        wide_w = '0;
        wide_w[NPINS-1:0] = wdata;
        out_nx  = w1_update(32'(out_q),     wide_w, stb.out_set,  stb.out_clr);
        rise_nx = w1_update(32'(rise_en_q), wide_w, stb.rise_set, stb.rise_clr);
        fall_nx = w1_update(32'(fall_en_q), wide_w, stb.fall_set, stb.fall_clr);
    end

    // Direction: reset makes every pin an input (bit = 1)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (stb.dir) begin
            dir_q <= wdata;
        end
    end

    // Output latch: whole-word write or masked set/clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (stb.out_wr) begin
            out_q <= wdata;
        end else begin
            out_q <= out_nx[NPINS-1:0];
        end
    end

    // Trigger enables, one register per edge polarity
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else begin
            rise_en_q <= rise_nx[NPINS-1:0];
            fall_en_q <= fall_nx[NPINS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_en_q <= '0;
        end else if (stb.bank_en) begin
            bank_en_q <= wdata[NBANKS-1:0];
        end
    end

endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status #(
    parameter int NPINS  = 32,
    parameter int BANK_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NPINS-1:0]          rise,
    input  logic [NPINS-1:0]          fall,
    input  logic [NPINS-1:0]          rise_en,
    input  logic [NPINS-1:0]          fall_en,
    input  logic                      clr_stb,
    input  logic [NPINS-1:0]          clr_mask,
    input  logic [NPINS/BANK_W-1:0]   bank_en,
    output logic [NPINS-1:0]          status_q,
    output logic [NPINS/BANK_W-1:0]   irq_o
);

    localparam int NBANKS = NPINS / BANK_W;

    logic [NPINS-1:0] event_v;
    logic [NPINS-1:0] clr_v;
    logic [NPINS-1:0] status_d;

    always_comb begin
        event_v  = (rise & rise_en) | (fall & fall_en);
        clr_v    = clr_stb ? clr_mask : '0;
        // a new event overrides a coincident clear
        status_d = (status_q & ~clr_v) | event_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        assign irq_o[b] = bank_en[b] & (|status_q[b*BANK_W +: BANK_W]);
    end

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
    import pin_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int BANK_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_sel,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [NPINS-1:0]        bus_wdata,
    output logic [NPINS-1:0]        bus_rdata,
    input  logic [NPINS-1:0]        pin_in,
    output logic [NPINS-1:0]        pin_out,
    output logic [NPINS-1:0]        pin_oe,
    output logic [NPINS/BANK_W-1:0] irq_o
);

    localparam int NBANKS = NPINS / BANK_W;

    logic              we;
    cfg_wr_t           cfg_stb;
    logic              stat_clr;
    logic [NPINS-1:0]  dir_q, out_q, rise_en_q, fall_en_q, status_q;
    logic [NBANKS-1:0] bank_en_q;
    logic [NPINS-1:0]  in_level, in_rise, in_fall;

    assign we       = bus_sel & bus_wr;
    assign cfg_stb  = decode_cfg_write(we, bus_addr);
    assign stat_clr = we && (bus_addr == OFS_STAT);

    pin_sync_edge #(
        .NPINS       (NPINS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (in_level),
        .rise   (in_rise),
        .fall   (in_fall)
    );

    pin_cfg_regs #(
        .NPINS  (NPINS),
        .NBANKS (NBANKS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (cfg_stb),
        .wdata     (bus_wdata),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .rise_en_q (rise_en_q),
        .fall_en_q (fall_en_q),
        .bank_en_q (bank_en_q)
    );

    pin_irq_status #(
        .NPINS  (NPINS),
        .BANK_W (BANK_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (in_rise),
        .fall     (in_fall),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .clr_stb  (stat_clr),
        .clr_mask (bus_wdata),
        .bank_en  (bank_en_q),
        .status_q (status_q),
        .irq_o    (irq_o)
    );

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;

    // Single-cycle read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_BANK_EN:                       bus_rdata[NBANKS-1:0] = bank_en_q;
            OFS_DIR:                           bus_rdata = dir_q;
            OFS_OUT, OFS_OUT_SET, OFS_OUT_CLR: bus_rdata = out_q;
            OFS_IN:                            bus_rdata = in_level;
            OFS_RISE_SET, OFS_RISE_CLR:        bus_rdata = rise_en_q;
            OFS_FALL_SET, OFS_FALL_CLR:        bus_rdata = fall_en_q;
            OFS_STAT:                          bus_rdata = status_q;
            default:                           bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk
    import pin_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int NBANKS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NBANKS-1:0] irq_o,
    input logic [NBANKS-1:0] bank_en,
    input logic [NPINS-1:0]  in_level,
    input logic [NPINS-1:0]  in_rise,
    input logic [NPINS-1:0]  in_fall,
    input logic [NPINS-1:0]  rise_en,
    input logic [NPINS-1:0]  fall_en,
    input logic [NPINS-1:0]  status
);

    logic [1:0]       age_q;
    logic [NPINS-1:0] evt;
    logic             wr_set, wr_clr, wr_stat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    assign evt     = (in_rise & rise_en) | (in_fall & fall_en);
    assign wr_set  = bus_sel && bus_wr && (bus_addr == OFS_OUT_SET);
    assign wr_clr  = bus_sel && bus_wr && (bus_addr == OFS_OUT_CLR);
    assign wr_stat = bus_sel && bus_wr && (bus_addr == OFS_STAT);

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R3

    AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((pin_out & $past(bus_wdata)) == '0)); // R4

    AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (in_level == $past(pin_in, 2))); // R5

    AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R10

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((status & $past(status)) == $past(status))); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & ~bank_en) == '0)); // R11

endmodule

bind pin_bank_ctrl pin_bank_chk #(
    .NPINS  (NPINS),
    .NBANKS (NPINS / BANK_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .irq_o     (irq_o),
    .bank_en   (bank_en_q),
    .in_level  (in_level),
    .in_rise   (in_rise),
    .in_fall   (in_fall),
    .rise_en   (rise_en_q),
    .fall_en   (fall_en_q),
    .status    (status_q)
);

// File: tb/test_pin_bank_ctrl.sv
`timescale 1ns/1ps
module test_pin_bank_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic [1:0]  irq_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pin_bank_ctrl i_pin_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [1:0] irq_exp(input logic [31:0] st, input logic [1:0] en);
        return {en[1] & (|st[31:16]), en[0] & (|st[15:0])};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] v;
        logic [31:0] model;
        logic [31:0] exp_st;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, v); chk("R1 dir", v, 32'hFFFF_FFFF);
        rd(8'h14, v); chk("R1 out", v, 32'h0);
        rd(8'h24, v); chk("R1 rise en", v, 32'h0);
        rd(8'h2C, v); chk("R1 fall en", v, 32'h0);
        rd(8'h34, v); chk("R1 status", v, 32'h0);
        rd(8'h08, v); chk("R1 bank en", v, 32'h0);
        chk("R1 oe", pin_oe, 32'h0);
        chk("R1 irq", {30'h0, irq_o}, 32'h0);

        // R2 direction / output enable
        for (int k = 0; k < 4; k++) begin
            v = 32'h0000_FFFF << (k * 5);
            wr(8'h10, v);
            chk("R2 oe", pin_oe, ~v);
        end
        wr(8'h10, 32'h0);
        chk("R2 all out", pin_oe, 32'hFFFF_FFFF);

        // R3 / R4 set and clear masks against an arithmetic model
        model = 32'h0;
        for (int k = 0; k < 8; k++) begin
            v = (32'h1357_9BDF * (k + 1)) ^ (32'h1 << (k * 4));
            if (k % 2 == 0) begin
                wr(8'h18, v); model = model | v;
                chk("R3 set", pin_out, model);
            end else begin
                wr(8'h1C, v); model = model & ~v;
                chk("R4 clear", pin_out, model);
            end
        end
        wr(8'h14, 32'hA5A5_0F0F);
        chk("R3 direct write", pin_out, 32'hA5A5_0F0F);
        rd(8'h18, v); chk("R3 read set port", v, 32'hA5A5_0F0F);
        rd(8'h1C, v); chk("R4 read clear port", v, 32'hA5A5_0F0F);
        wr(8'h18, 32'h0);
        chk("R3 zero mask", pin_out, 32'hA5A5_0F0F);
        wr(8'h1C, 32'h0);
        chk("R4 zero mask", pin_out, 32'hA5A5_0F0F);

        // R5 input sample latency, pins driven as outputs (dir = 0)
        @(negedge clk);
        pin_in = 32'hC3C3_3C3C;
        rd(8'h20, v); chk("R5 old level", v, 32'h0);
        rd(8'h20, v); chk("R5 new level", v, 32'hC3C3_3C3C);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R5 as input", v, 32'hC3C3_3C3C);
        @(negedge clk);
        pin_in = 32'h0;
        repeat (4) @(negedge clk);

        // R6 trigger enable set / clear
        wr(8'h24, 32'hF0F0_0001); wr(8'h28, 32'h3000_0000);
        rd(8'h28, v); chk("R6 rise", v, 32'hC0F0_0001);
        wr(8'h2C, 32'h0000_FF00); wr(8'h30, 32'h0000_0F00);
        rd(8'h2C, v); chk("R6 fall", v, 32'h0000_F000);
        wr(8'h28, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R6 rise cleared", v, 32'h0);

        // R7 / R8 / R11: sweep every pin through every trigger mode
        wr(8'h08, 32'h3);
        for (int p = 0; p < 32; p++) begin
            for (int m = 0; m < 4; m++) begin
                wr(8'h28, 32'hFFFF_FFFF);
                wr(8'h30, 32'hFFFF_FFFF);
                wr(8'h34, 32'hFFFF_FFFF);
                if (m[0]) wr(8'h24, 32'h1 << p);
                if (m[1]) wr(8'h2C, 32'h1 << p);
                @(negedge clk);
                pin_in[p] = 1'b1;
                repeat (3) @(negedge clk);
                exp_st = m[0] ? (32'h1 << p) : 32'h0;
                rd(8'h34, v); chk("R7 rising", v, exp_st);
                chk("R11 irq rise", {30'h0, irq_o}, {30'h0, irq_exp(exp_st, 2'b11)});
                wr(8'h34, 32'hFFFF_FFFF);
                @(negedge clk);
                pin_in[p] = 1'b0;
                repeat (3) @(negedge clk);
                exp_st = m[1] ? (32'h1 << p) : 32'h0;
                rd(8'h34, v); chk("R8 falling", v, exp_st);
            end
        end
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h34, 32'hFFFF_FFFF);

        // R9 partial write-one clear
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h24, 32'h0010_0001);
        @(negedge clk);
        pin_in = 32'h0010_0001;
        repeat (3) @(negedge clk);
        rd(8'h34, v); chk("R9 both set", v, 32'h0010_0001);
        wr(8'h34, 32'h0000_0001);
        rd(8'h34, v); chk("R9 one cleared", v, 32'h0010_0000);
        wr(8'h34, 32'h0);
        rd(8'h34, v); chk("R9 zero write", v, 32'h0010_0000);

        // R11 half enable gating with status bit 20 set
        wr(8'h08, 32'h1);
        chk("R11 upper gated", {30'h0, irq_o}, 32'h0);
        wr(8'h08, 32'h2);
        chk("R11 upper on", {30'h0, irq_o}, 32'h2);
        wr(8'h08, 32'h0);
        chk("R11 all off", {30'h0, irq_o}, 32'h0);

        // R10 event coinciding with a clear of the same bit
        @(negedge clk);
        pin_in = 32'h0;
        repeat (3) @(negedge clk);
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h24, 32'h0000_0020);
        @(negedge clk);
        pin_in[5] = 1'b1;
        @(negedge clk);
        wr(8'h34, 32'h0000_0020);
        rd(8'h34, v); chk("R10 event wins", v & 32'h0000_0020, 32'h0000_0020);
        wr(8'h34, 32'h0000_0020);
        rd(8'h34, v); chk("R10 later clear", v, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule